// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the processor status word that sits beside the ALU. Each cycle the ALU presents its result together with the carry out of every bit position. The block derives five arithmetic flags for the active operand size (byte or word): carry, zero, signed overflow, negative and half-carry. It stores each flag only when that flag's update enable is high. Software can also write the register, but a hardware update of a bit in the same cycle takes precedence.

The register also holds a 3-bit interrupt priority field, which software may write unless the nesting-disable control is high. This field is placed under an external high-priority bit to give a 4-bit effective level. A repeat-in-progress indicator from the loop sequencer is shown directly in the word and cannot be written. Carry-chained add and subtract operations only ever clear the zero flag, so a zero test across several words works along the chain.

Top module: `alu_status_reg`

## Requirements
- R1: After reset every stored bit is 0, so `sr_o` reads 0x0000 (with `rpt_active_i` low) and `ipl_o` reads `{ipl_hi_i,3'b000}`.
- R2: Bits 15..9 of `sr_o` always read 0, including after a software write of all ones.
- R3: The half-carry flag (bit 8) takes `carry_i[3]` in byte mode and `carry_i[7]` in word mode, where `carry_i[k]` is the carry out of result bit k.
- R4: Negative (bit 3) takes the MSb of the result and carry (bit 0) takes the carry out of the MSb, using bit 7 in byte mode and bit 15 in word mode.
- R5: Overflow (bit 2) is the XOR of the carry out of the MSb and the carry out of the bit below it, for the active size.
- R6: On an ordinary operation zero (bit 1) is set when the size-masked result is zero and cleared otherwise; the upper byte is ignored in byte mode.
- R7: When `chain_op_i` is high, a zero update can only clear bit 1 and never set it.
- R8: `upd_en_i` has one enable per flag (bit0 C, bit1 Z, bit2 OV, bit3 N, bit4 DC). A flag whose enable is low keeps its value. An enabled flag shows its new value one clock after the edge.
- R9: A software write (`sw_we_i`) loads bits 8, 7..5, 3..0 from `sw_wdata_i` at the same positions, one clock later. For a bit whose hardware enable is also high in that cycle, the hardware value is stored.
- R10: While `nest_dis_i` is high, software writes leave the priority field (bits 7..5) unchanged.
- R11: Bit 4 equals `rpt_active_i` in the same cycle; software writes to bit 4 have no effect.
- R12: `ipl_o` equals `{ipl_hi_i, sr_o[7:5]}`, which is the field value plus 8 when `ipl_hi_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_i | input | 16 | ALU result |
| carry_i | input | 16 | Carry out of each result bit position |
| byte_mode_i | input | 1 | 1 = byte operation, 0 = word operation |
| chain_op_i | input | 1 | Carry-chained add/subtract (zero flag clear-only) |
| upd_en_i | input | 5 | Per-flag hardware update enables {DC,N,OV,Z,C} |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 16 | Software write data |
| rpt_active_i | input | 1 | Repeat loop in progress |
| nest_dis_i | input | 1 | Makes the priority field read-only to software |
| ipl_hi_i | input | 1 | High bit of the effective priority level |
| sr_o | output | 16 | Packed status word |
| ipl_o | output | 4 | Effective 4-bit priority level |

## Verification
Flag captures and software writes are registered, so their effect on `sr_o` appears one clock after the edge that samples them. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and checks there, half a period after the capturing edge. The repeat bit and `ipl_o` are combinational from their inputs and the stored field, so they are checked in the same cycle, a short delay after the input changes. Expected flags come from a separate model in the bench: widened sums for the carries and sign comparison for overflow.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
  // flag indices inside the per-flag vectors
  localparam int FLAG_CNT = 5;
  localparam int FL_C  = 0;
  localparam int FL_Z  = 1;
  localparam int FL_OV = 2;
  localparam int FL_N  = 3;
  localparam int FL_DC = 4;

  // positions inside the packed status word
  localparam int SR_W      = 16;
  localparam int PRIO_W    = 3;
  localparam int POS_C     = 0;
  localparam int POS_Z     = 1;
  localparam int POS_OV    = 2;
  localparam int POS_N     = 3;
  localparam int POS_RA    = 4;
  localparam int POS_PRIO  = 5;
  localparam int POS_DC    = 8;
  localparam int POS_UNIMP = 9;

  // pack the five flags as they appear at their word positions
  function automatic logic [FLAG_CNT-1:0] pick_sw_flags(input logic [SR_W-1:0] w);
    logic [FLAG_CNT-1:0] f;
    f[FL_C]  = w[POS_C];
    f[FL_Z]  = w[POS_Z];
    f[FL_OV] = w[POS_OV];
    f[FL_N]  = w[POS_N];
    f[FL_DC] = w[POS_DC];
    return f;
  endfunction
endpackage

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   res_i,
  input  logic [DATA_W-1:0]   carry_i,
  input  logic                byte_mode_i,
  input  logic                chain_op_i,
  input  logic                z_prev_i,
  output logic [FLAG_CNT-1:0] hw_flags_o
);
  localparam int BYTE_W   = DATA_W / 2;
  localparam int B_MSB    = BYTE_W - 1;
  localparam int W_MSB    = DATA_W - 1;
  localparam int B_HALF   = BYTE_W / 2 - 1;
  localparam int W_HALF   = BYTE_W - 1;

  function automatic logic size_zero(input logic [DATA_W-1:0] r, input logic bm);
    return bm ? (r[BYTE_W-1:0] == '0) : (r == '0);
  endfunction

  function automatic logic size_ovf(input logic [DATA_W-1:0] cy, input logic bm);
    return bm ? (cy[B_MSB] ^ cy[B_MSB-1]) : (cy[W_MSB] ^ cy[W_MSB-1]);
  endfunction

  logic res_zero;
  logic unused_carry;

  assign res_zero = size_zero(res_i, byte_mode_i);
  assign unused_carry = ^carry_i;

  always_comb begin
    hw_flags_o          = '0;
    hw_flags_o[FL_C]    = byte_mode_i ? carry_i[B_MSB]  : carry_i[W_MSB];
    hw_flags_o[FL_N]    = byte_mode_i ? res_i[B_MSB]    : res_i[W_MSB];
    hw_flags_o[FL_DC]   = byte_mode_i ? carry_i[B_HALF] : carry_i[W_HALF];
    hw_flags_o[FL_OV]   = size_ovf(carry_i, byte_mode_i);
    // chained ops may only clear Z
    hw_flags_o[FL_Z]    = chain_op_i ? (z_prev_i & res_zero) : res_zero;
  end
endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
  import alu_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FLAG_CNT-1:0] hw_flags_i,
  input  logic [FLAG_CNT-1:0] upd_en_i,
  input  logic                sw_we_i,
  input  logic [FLAG_CNT-1:0] sw_flags_i,
  output logic [FLAG_CNT-1:0] flags_q
);
  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags_q[i] <= 1'b0;
      else if (upd_en_i[i]) flags_q[i] <= hw_flags_i[i];
      else if (sw_we_i)     flags_q[i] <= sw_flags_i[i];
    end

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en_i[i] |=> flags_q[i] == $past(hw_flags_i[i])); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en_i[i] && !sw_we_i) |=> $stable(flags_q[i])); // R8
  end
endmodule

// File: rtl/alu_prio_field.sv
module alu_prio_field
  import alu_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we_i,
  input  logic [PRIO_W-1:0] sw_prio_i,
  input  logic              nest_dis_i,
  input  logic              ipl_hi_i,
  output logic [PRIO_W-1:0] prio_q,
  output logic [PRIO_W:0]   ipl_o
);
  logic prio_wr;

  assign prio_wr = sw_we_i && !nest_dis_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= '0;
    else if (prio_wr) prio_q <= sw_prio_i;
  end

  assign ipl_o = {ipl_hi_i, prio_q};

  AST_PRIO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    nest_dis_i |=> $stable(prio_q)); // R10

  AST_PRIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we_i && !nest_dis_i) |=> prio_q == $past(sw_prio_i)); // R9
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] carry_i,
  input  logic              byte_mode_i,
  input  logic              chain_op_i,
  input  logic [4:0]        upd_en_i,
  input  logic              sw_we_i,
  input  logic [SR_W-1:0]   sw_wdata_i,
  input  logic              rpt_active_i,
  input  logic              nest_dis_i,
  input  logic              ipl_hi_i,
  output logic [SR_W-1:0]   sr_o,
  output logic [PRIO_W:0]   ipl_o
);
  localparam int B_HALF = DATA_W / 4 - 1;

  logic [FLAG_CNT-1:0] hw_flags;
  logic [FLAG_CNT-1:0] sw_flags;
  logic [FLAG_CNT-1:0] flags_q;
  logic [PRIO_W-1:0]   prio_q;
  logic                unused_wdata;

  assign sw_flags     = pick_sw_flags(sw_wdata_i);
  assign unused_wdata = ^{sw_wdata_i[SR_W-1:POS_UNIMP], sw_wdata_i[POS_RA]};

  alu_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .res_i       (res_i),
    .carry_i     (carry_i),
    .byte_mode_i (byte_mode_i),
    .chain_op_i  (chain_op_i),
    .z_prev_i    (flags_q[FL_Z]),
    .hw_flags_o  (hw_flags)
  );

  alu_flag_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_flags_i (hw_flags),
    .upd_en_i   (upd_en_i),
    .sw_we_i    (sw_we_i),
    .sw_flags_i (sw_flags),
    .flags_q    (flags_q)
  );

  alu_prio_field u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we_i    (sw_we_i),
    .sw_prio_i  (sw_wdata_i[POS_PRIO +: PRIO_W]),
    .nest_dis_i (nest_dis_i),
    .ipl_hi_i   (ipl_hi_i),
    .prio_q     (prio_q),
    .ipl_o      (ipl_o)
  );

  always_comb begin
    sr_o                        = '0;
    sr_o[POS_C]                 = flags_q[FL_C];
    sr_o[POS_Z]                 = flags_q[FL_Z];
    sr_o[POS_OV]                = flags_q[FL_OV];
    sr_o[POS_N]                 = flags_q[FL_N];
    sr_o[POS_RA]                = rpt_active_i;
    sr_o[POS_PRIO +: PRIO_W]    = prio_q;
    sr_o[POS_DC]                = flags_q[FL_DC];
  end

  AST_CHAIN_Z_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i[FL_Z] && chain_op_i && !sr_o[POS_Z]) |=> !sr_o[POS_Z]); // R7

  AST_DC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i[FL_DC] && byte_mode_i) |=> sr_o[POS_DC] == $past(carry_i[B_HALF])); // R3

  AST_ZERO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i[FL_Z] && !chain_op_i && !byte_mode_i && res_i == '0) |=> sr_o[POS_Z]); // R6
endmodule

// File: tb/alu_status_reg_test.sv
module alu_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] res_i = '0, carry_i = '0, sw_wdata_i = '0;
  logic        byte_mode_i = 1'b0, chain_op_i = 1'b0, sw_we_i = 1'b0;
  logic [4:0]  upd_en_i = '0;
  logic        rpt_active_i = 1'b0, nest_dis_i = 1'b0, ipl_hi_i = 1'b0;
  logic [15:0] sr_o;
  logic [3:0]  ipl_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_status_reg uut (.*);

  // bench model: expected stored bits
  logic [2:0] m_prio = '0;
  logic       m_dc = 0, m_n = 0, m_ov = 0, m_z = 0, m_c = 0;

  function automatic logic [15:0] model_sr(logic ra);
    return {7'b0, m_dc, m_prio, ra, m_n, m_ov, m_z, m_c};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ripple(logic [15:0] a, logic [15:0] b);
    logic [15:0] cy;
    logic c = 1'b0;
    for (int k = 0; k < 16; k++) begin
      cy[k] = (a[k] & b[k]) | (a[k] & c) | (b[k] & c);
      c = cy[k];
    end
    return cy;
  endfunction

  // drive an add, capture with the given enables, update model
  task automatic do_add(logic [15:0] a, logic [15:0] b, logic bm, logic ch,
                        logic [4:0] en);
    logic [16:0] w;
    logic [8:0]  s8;
    logic        sa, sb, sr, zero;
    @(negedge clk);
    res_i = a + b; carry_i = ripple(a, b);
    byte_mode_i = bm; chain_op_i = ch; upd_en_i = en;
    if (bm) begin
      s8 = {1'b0, a[7:0]} + {1'b0, b[7:0]};
      sa = a[7]; sb = b[7]; sr = s8[7]; zero = (s8[7:0] == 0);
      if (en[4]) m_dc = ((a[3:0] + b[3:0]) > 15);
      if (en[0]) m_c = s8[8];
    end else begin
      w = {1'b0, a} + {1'b0, b};
      sa = a[15]; sb = b[15]; sr = w[15]; zero = (w[15:0] == 0);
      if (en[4]) m_dc = ((a[7:0] + b[7:0]) > 255);
      if (en[0]) m_c = w[16];
    end
    if (en[3]) m_n = sr;
    if (en[2]) m_ov = (sa == sb) && (sr != sa);
    if (en[1]) m_z = ch ? (m_z & zero) : zero;
    @(negedge clk);
    upd_en_i = '0; chain_op_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset sr", sr_o, 16'h0000);
    chk("R1 reset ipl", {12'b0, ipl_o}, 16'h0000);
  endtask

  task automatic t_byte_ops;
    do_add(16'h007F, 16'h0001, 1, 0, 5'h1F);
    chk("R4 R5 byte 7F+01", sr_o, model_sr(0));
    do_add(16'h00FF, 16'h0001, 1, 0, 5'h1F);
    chk("R3 R4 R6 byte FF+01", sr_o, model_sr(0));
    do_add(16'h0080, 16'h0080, 1, 0, 5'h1F);
    chk("R5 byte 80+80", sr_o, model_sr(0));
    do_add(16'h12FF, 16'h0001, 1, 0, 5'h1F);
    chk("R6 byte upper ignored", sr_o[1], 1'b1);
    do_add(16'h00F0, 16'h0010, 1, 0, 5'h1F);
    chk("R3 byte DC from bit3", sr_o, model_sr(0));
  endtask

  task automatic t_word_ops;
    do_add(16'h7FFF, 16'h0001, 0, 0, 5'h1F);
    chk("R4 R5 word 7FFF+1", sr_o, model_sr(0));
    do_add(16'hFFFF, 16'h0001, 0, 0, 5'h1F);
    chk("R4 R6 word FFFF+1", sr_o, model_sr(0));
    do_add(16'h00F0, 16'h0010, 0, 0, 5'h1F);
    chk("R3 word DC from bit7", sr_o[8], 1'b1);
    do_add(16'h8000, 16'h8000, 0, 0, 5'h1F);
    chk("R5 word 8000+8000", sr_o, model_sr(0));
  endtask

  task automatic t_chain;
    do_add(16'h0001, 16'h0001, 0, 0, 5'h02);
    do_add(16'h0000, 16'h0000, 0, 1, 5'h02);
    chk("R7 chain zero keeps Z clear", sr_o[1], 1'b0);
    do_add(16'h0000, 16'h0000, 0, 0, 5'h02);
    do_add(16'hFFFF, 16'h0001, 0, 1, 5'h02);
    chk("R7 chain zero keeps Z set", sr_o[1], 1'b1);
    do_add(16'h0003, 16'h0001, 0, 1, 5'h02);
    chk("R7 chain nonzero clears Z", sr_o[1], 1'b0);
  endtask

  task automatic t_enable;
    do_add(16'h0000, 16'h0000, 0, 0, 5'h1F);
    do_add(16'hFFFF, 16'hFFFF, 0, 0, 5'h01);
    chk("R8 only C updates", sr_o, model_sr(0));
    chk("R8 C set", sr_o[0], 1'b1);
  endtask

  task automatic t_sw_write;
    @(negedge clk); sw_we_i = 1; sw_wdata_i = 16'hFFFF;
    @(negedge clk); sw_we_i = 0;
    {m_dc, m_prio, m_n, m_ov, m_z, m_c} = 8'hFF;
    chk("R2 R9 R11 write all ones", sr_o, 16'h01EF);
    ipl_hi_i = 1; #1;
    chk("R12 ipl with high bit", {12'b0, ipl_o}, 16'h000F);
    ipl_hi_i = 0; #1;
    chk("R12 ipl without high bit", {12'b0, ipl_o}, 16'h0007);
    // hardware update beats software on C, software clears the rest
    @(negedge clk);
    res_i = 16'h0000; carry_i = 16'h8000; byte_mode_i = 0; upd_en_i = 5'h01;
    sw_we_i = 1; sw_wdata_i = 16'h0000;
    @(negedge clk); sw_we_i = 0; upd_en_i = 0;
    {m_dc, m_prio, m_n, m_ov, m_z} = 7'h0; m_c = 1;
    chk("R9 hardware wins on C", sr_o, model_sr(0));
  endtask

  task automatic t_nest;
    @(negedge clk); sw_we_i = 1; sw_wdata_i = 16'h00E0;
    @(negedge clk); nest_dis_i = 1; sw_wdata_i = 16'h0000;
    @(negedge clk); sw_we_i = 0;
    m_prio = 3'd7; m_c = 0;
    chk("R10 field locked", sr_o, model_sr(0));
    @(negedge clk); nest_dis_i = 0; sw_we_i = 1; sw_wdata_i = 16'h0040;
    @(negedge clk); sw_we_i = 0;
    m_prio = 3'd2;
    chk("R10 R9 field written when unlocked", sr_o, model_sr(0));
    ipl_hi_i = 1; #1;
    chk("R12 level 2 plus 8", {12'b0, ipl_o}, 16'h000A);
    ipl_hi_i = 0;
  endtask

  task automatic t_repeat;
    @(negedge clk); rpt_active_i = 1; #1;
    chk("R11 repeat shown same cycle", sr_o, model_sr(1));
    rpt_active_i = 0; sw_we_i = 1; sw_wdata_i = {8'h0, 3'd2, 5'h10};
    @(negedge clk); sw_we_i = 0;
    chk("R11 bit4 not writable", sr_o, model_sr(0));
  endtask

  initial begin
    #20; @(negedge clk); rst_n = 1;
    t_reset();
    t_byte_ops();
    t_word_ops();
    t_chain();
    t_enable();
    t_sw_write();
    t_nest();
    t_repeat();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule